// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one counting-semaphore cell used by several hardware threads to synchronise with each other. It holds an unsigned count that requesters reach through a small set of access views selected per access. A P operation is a read through one of the two semaphore views. It returns the count and takes one unit from it when the count is above zero. A V operation is a write through either semaphore view. It adds one unit, stops at the all-ones value, and ignores its write data.

The blocking semaphore view differs from the polling one in a single way. When the count is zero, a blocking P returns a block indication and records the requester's number in a waiting mask. Every V then pulses a wake line for each recorded requester and clears the mask. A plain view gives direct read access to the count. A tag view exposes three software flag bits. The queue-style views read as zero and do nothing.

Reads and writes arrive on separate channels and may both be valid in the same cycle. The write is applied first. Every read response and wake pulse is registered and appears one cycle after the request. Halting and restarting a requester, and the bus in front of the cell, belong to the surrounding logic.

Top module: `pv_semaphore_cell`

## Requirements
- R1: A read through view 4 (blocking) or view 5 (polling) returns the count in the response one cycle later and lowers the count by one when it was above zero.
- R2: A view-4 read on a zero count responds with rsp_block_o=1 and data 0, leaves the count at 0 and sets the mask bit of rd_id_i.
- R3: A view-5 read on a zero count responds with data 0 and rsp_block_o=0, and leaves the count and the waiting mask unchanged.
- R4: A write through view 4 or view 5 raises the count by one unless it is already 0xFFFF, whatever the write data.
- R5: One cycle after a view-4 or view-5 write, wake_o equals the waiting mask held before that write for exactly one cycle, and the mask is then empty.
- R6: A view-0 read returns the count without changing it, and a view-0 write has no effect.
- R7: Reads through views 2, 3, 6 and 7 return 0 without blocking, and writes through them have no effect.
- R8: A view-1 read returns flag T in bit 16, F in bit 1 and E in bit 0, with all other bits zero (bit 17, the queue flag, is zero). A view-1 write loads those three bits from the same positions and does not change the count.
- R9: When a read and a write are valid in the same cycle, the read observes the state after the write.
- R10: After reset the count, the flags and the waiting mask are zero, and rsp_valid_o, rsp_block_o and wake_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read request valid |
| rd_view_i | input | 3 | View selected for the read |
| rd_id_i | input | ID_W | Number of the requester issuing the read |
| wr_valid_i | input | 1 | Write request valid |
| wr_view_i | input | 3 | View selected for the write |
| wr_data_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the read |
| rsp_data_o | output | DATA_W | Read response data, zero when no response |
| rsp_block_o | output | 1 | Read was a blocking P on an empty semaphore |
| wake_o | output | NUM_REQ | One-cycle wake pulse per waiting requester |

## Verification
The bench targets the count at both of its ends. A design that let the count wrap would show 0 after the 65536th V. A design that went negative would return 0xFFFF after a P on zero. Reads that coincide with writes are driven deliberately. A design that evaluated P against the old count would block a requester while a V is landing in the same cycle. The bench also checks that wake pulses last exactly one cycle and carry every waiter. A design that woke a single waiter, or kept the mask after the pulse, would mismatch the reference model. Polling on zero and the queue views check that nothing is recorded or changed on a path that must have no effect.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

  typedef enum logic [2:0] {
    VIEW_RAW     = 3'd0,
    VIEW_TAG     = 3'd1,
    VIEW_EF_WAIT = 3'd2,
    VIEW_EF_POLL = 3'd3,
    VIEW_PV_WAIT = 3'd4,
    VIEW_PV_POLL = 3'd5,
    VIEW_RSV6    = 3'd6,
    VIEW_RSV7    = 3'd7
  } view_e;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } tag_t;

  localparam int TAG_T_BIT    = 16;
  localparam int TAG_QUEUE_BIT = 17;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_E_BIT    = 0;

  // saturating increment against a ceiling
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] ceil);
    return (v >= ceil) ? v : v + 32'd1;
  endfunction

  // decrement that stops at zero
  function automatic logic [31:0] floor_dec(input logic [31:0] v);
    return (v != 32'd0) ? v - 32'd1 : v;
  endfunction

  function automatic logic [31:0] pack_tag(input tag_t tg);
    logic [31:0] w;
    w = '0;
    w[TAG_T_BIT] = tg.t;
    w[TAG_F_BIT] = tg.f;
    w[TAG_E_BIT] = tg.e;
    w[TAG_QUEUE_BIT] = 1'b0;
    return w;
  endfunction

  function automatic tag_t unpack_tag(input logic [31:0] w);
    tag_t tg;
    tg.t = w[TAG_T_BIT];
    tg.f = w[TAG_F_BIT];
    tg.e = w[TAG_E_BIT];
    return tg;
  endfunction

  function automatic logic is_sem_view(input logic [2:0] v);
    return (v == VIEW_PV_WAIT) || (v == VIEW_PV_POLL);
  endfunction

endpackage

// File: rtl/semcell_counter.sv
module semcell_counter
  import semcell_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_inc_i,
  input  logic             p_take_i,
  output logic [CNT_W-1:0] count_q_o,
  output logic [CNT_W-1:0] count_mid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [31:0]      inc_w;
  logic [31:0]      dec_w;

  // V is applied first, P sees the result (R9)
  always_comb begin
    inc_w       = sat_inc(32'(count_q), 32'(CNT_MAX));
    count_mid_o = v_inc_i ? inc_w[CNT_W-1:0] : count_q;
    dec_w       = floor_dec(32'(count_mid_o));
    count_d     = p_take_i ? dec_w[CNT_W-1:0] : count_mid_o;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_q_o = count_q;

  a_r4_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX && v_inc_i && !p_take_i) |=> (count_q == CNT_MAX));

  a_r4_inc_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != CNT_MAX && v_inc_i && !p_take_i) |=> (count_q == $past(count_q) + 1'b1));

  a_r1_take_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != '0 && p_take_i && !v_inc_i) |=> (count_q == $past(count_q) - 1'b1));

  a_r2_zero_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && p_take_i && !v_inc_i) |=> (count_q == '0));

endmodule

// File: rtl/semcell_waitlist.sv
module semcell_waitlist #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               v_inc_i,
  input  logic               block_i,
  input  logic [ID_W-1:0]    block_id_i,
  output logic [NUM_REQ-1:0] wake_o
);

  logic [NUM_REQ-1:0] mask_q;
  logic [NUM_REQ-1:0] mask_d;
  logic [NUM_REQ-1:0] wake_q;
  logic [NUM_REQ-1:0] block_vec;

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_sel
      assign block_vec[g] = block_i && (block_id_i == ID_W'(g));
    end
  endgenerate

  always_comb begin
    mask_d = v_inc_i ? '0 : (mask_q | block_vec);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wake_q <= '0;
    end else begin
      mask_q <= mask_d;
      wake_q <= v_inc_i ? mask_q : '0;
    end
  end

  assign wake_o = wake_q;

  // a block is never raised while a V lands (R9)
  a_r9_no_block_with_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |-> !v_inc_i);

  a_r5_mask_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_inc_i |=> (mask_q == '0));

  a_r5_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_inc_i |=> (wake_o == '0));

  a_r2_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> mask_q[$past(block_id_i)]);

endmodule

// File: rtl/semcell_tag.sv
module semcell_tag
  import semcell_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tag_t              tag_mid_o
);

  tag_t tag_q;
  tag_t tag_new;
  logic [31:0] wide_w;
  logic unused_wide;

  always_comb begin
    wide_w  = 32'(wdata_i);
    tag_new = unpack_tag(wide_w);
  end

  assign unused_wide = ^wide_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     tag_q <= '0;
    else if (load_i) tag_q <= tag_new;
  end

  assign tag_mid_o = load_i ? tag_new : tag_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tag_q));

endmodule

// File: rtl/semcell_resp.sv
module semcell_resp
  import semcell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [2:0]        rd_view_i,
  input  logic [CNT_W-1:0]  count_mid_i,
  input  tag_t              tag_mid_i,
  output logic              p_take_o,
  output logic              block_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_block_o
);

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_block_q;
  logic [DATA_W-1:0] data_d;
  logic [31:0]       tag_word;

  assign p_take_o = rd_valid_i && is_sem_view(rd_view_i);
  assign block_o  = rd_valid_i && (rd_view_i == VIEW_PV_WAIT) && (count_mid_i == '0);

  always_comb begin
    tag_word = pack_tag(tag_mid_i);
    data_d   = '0;
    if (rd_valid_i) begin
      unique case (view_e'(rd_view_i))
        VIEW_RAW, VIEW_PV_WAIT, VIEW_PV_POLL: data_d = DATA_W'(count_mid_i);
        VIEW_TAG: data_d = tag_word[DATA_W-1:0];
        default:  data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_block_q <= 1'b0;
    end else begin
      rsp_valid_q <= rd_valid_i;
      rsp_data_q  <= data_d;
      rsp_block_q <= block_o;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_block_o = rsp_block_q;

  a_r7_queue_views_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !is_sem_view(rd_view_i) && rd_view_i != VIEW_RAW && rd_view_i != VIEW_TAG)
    |=> (rsp_valid_o && rsp_data_o == '0 && !rsp_block_o));

  a_r3_poll_never_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_view_i == VIEW_PV_POLL) |=> !rsp_block_o);

  a_r2_block_has_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_block_o |-> (rsp_valid_o && rsp_data_o == '0));

endmodule

// File: rtl/pv_semaphore_cell.sv
module pv_semaphore_cell
  import semcell_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_valid_i,
  input  logic [2:0]         rd_view_i,
  input  logic [ID_W-1:0]    rd_id_i,
  input  logic               wr_valid_i,
  input  logic [2:0]         wr_view_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               rsp_block_o,
  output logic [NUM_REQ-1:0] wake_o
);

  // named internal events
  logic             v_event;
  logic             tag_load;
  logic             p_event;
  logic             block_event;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_mid;
  tag_t             tag_mid;

  assign v_event  = wr_valid_i && is_sem_view(wr_view_i);
  assign tag_load = wr_valid_i && (wr_view_i == VIEW_TAG);

  semcell_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .v_inc_i     (v_event),
    .p_take_i    (p_event),
    .count_q_o   (count_q),
    .count_mid_o (count_mid)
  );

  semcell_tag #(.DATA_W(DATA_W)) u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tag_load),
    .wdata_i   (wr_data_i),
    .tag_mid_o (tag_mid)
  );

  semcell_resp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_valid_i  (rd_valid_i),
    .rd_view_i   (rd_view_i),
    .count_mid_i (count_mid),
    .tag_mid_i   (tag_mid),
    .p_take_o    (p_event),
    .block_o     (block_event),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_block_o (rsp_block_o)
  );

  semcell_waitlist #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_waitlist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .v_inc_i    (v_event),
    .block_i    (block_event),
    .block_id_i (rd_id_i),
    .wake_o     (wake_o)
  );

  // raw view and queue-view writes leave the count alone (R6, R7)
  a_r6_raw_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !is_sem_view(wr_view_i) && !p_event) |=> (count_q == $past(count_q)));

  a_r9_block_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_event |-> (count_q == '0 && !v_event));

  a_r10_quiet_after_reset: assert property (@(posedge clk_i)
    $past(!rst_ni) |-> (!rsp_valid_o && !rsp_block_o && wake_o == '0 && count_q == '0));

endmodule

// File: tb/pv_semaphore_cell_tb_top.sv
`timescale 1ns/1ps
module pv_semaphore_cell_tb_top;

  localparam int NREQ = 8;
  localparam int MAXC = 65535;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [2:0]  rd_view_i = '0;
  logic [2:0]  rd_id_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [2:0]  wr_view_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        rsp_block_o;
  logic [7:0]  wake_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  int       m_cnt = 0;
  bit [7:0] m_mask = '0;
  bit       m_t = 0, m_f = 0, m_e = 0;

  always #2 clk_i = ~clk_i;

  pv_semaphore_cell #(.NUM_REQ(NREQ)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_valid_i(rd_valid_i), .rd_view_i(rd_view_i), .rd_id_i(rd_id_i),
    .wr_valid_i(wr_valid_i), .wr_view_i(wr_view_i), .wr_data_i(wr_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .rsp_block_o(rsp_block_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, compare at the next falling edge
  task automatic step(input bit rv, input logic [2:0] rview, input logic [2:0] rid,
                      input bit wv, input logic [2:0] wview, input logic [31:0] wd,
                      input string req);
    bit [7:0]    e_wake = '0;
    bit          e_rv = 0, e_blk = 0;
    logic [31:0] e_data = '0;
    rd_valid_i = rv; rd_view_i = rview; rd_id_i = rid;
    wr_valid_i = wv; wr_view_i = wview; wr_data_i = wd;
    if (wv) begin
      if (wview == 3'd4 || wview == 3'd5) begin
        e_wake = m_mask;
        m_mask = '0;
        if (m_cnt < MAXC) m_cnt++;
      end else if (wview == 3'd1) begin
        m_t = wd[16]; m_f = wd[1]; m_e = wd[0];
      end
    end
    if (rv) begin
      e_rv = 1;
      case (rview)
        3'd0: e_data = m_cnt;
        3'd1: e_data = (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
        3'd4, 3'd5: begin
          e_data = m_cnt;
          if (m_cnt > 0) m_cnt--;
          else if (rview == 3'd4) begin
            e_blk = 1;
            m_mask[rid] = 1'b1;
          end
        end
        default: e_data = '0;
      endcase
    end
    @(negedge clk_i);
    check(req, "rsp_valid", 32'(rsp_valid_o), 32'(e_rv));
    check(req, "rsp_data", rsp_data_o, e_data);
    check(req, "rsp_block", 32'(rsp_block_o), 32'(e_blk));
    check(req, "wake", 32'(wake_o), 32'(e_wake));
  endtask

  task automatic idle(input string req);
    step(0, 3'd0, 3'd0, 0, 3'd0, 32'd0, req);
  endtask

  task automatic rd(input logic [2:0] v, input logic [2:0] id, input string req);
    step(1, v, id, 0, 3'd0, 32'd0, req);
  endtask

  task automatic wr(input logic [2:0] v, input logic [31:0] d, input string req);
    step(0, 3'd0, 3'd0, 1, v, d, req);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state (R10)
    check("R10", "rsp_valid", 32'(rsp_valid_o), 0);
    check("R10", "wake", 32'(wake_o), 0);
    idle("R10");
    rd(3'd0, 0, "R10");
    rd(3'd1, 0, "R10");

    // raw view (R6)
    wr(3'd0, 32'h1234, "R6");
    rd(3'd0, 0, "R6");

    // V with data ignored (R4)
    wr(3'd5, 32'hDEAD, "R4");
    wr(3'd4, 32'h0, "R4");
    rd(3'd0, 0, "R4");
    wr(3'd0, 32'h7, "R6");
    rd(3'd0, 0, "R6");

    // P reads (R1)
    rd(3'd5, 1, "R1");
    rd(3'd4, 1, "R1");
    rd(3'd0, 0, "R1");

    // poll on zero (R3): no block, no mask entry
    rd(3'd5, 6, "R3");
    wr(3'd5, 0, "R3");
    rd(3'd5, 0, "R3");

    // blocking P on zero and wake of all (R2, R5)
    rd(3'd4, 3, "R2");
    rd(3'd4, 5, "R2");
    rd(3'd0, 0, "R2");
    wr(3'd4, 0, "R5");
    idle("R5");
    wr(3'd5, 0, "R5");

    // queue and reserved views (R7)
    for (int v = 2; v < 8; v++) begin
      if (v == 4 || v == 5) continue;
      rd(3'(v), 0, "R7");
      wr(3'(v), 32'hFFFF_FFFF, "R7");
    end
    rd(3'd0, 0, "R7");

    // tag view (R8)
    wr(3'd1, 32'hFFFF_FFFF, "R8");
    rd(3'd1, 0, "R8");
    rd(3'd0, 0, "R8");
    wr(3'd1, 32'h0001_0000, "R8");
    rd(3'd1, 0, "R8");
    wr(3'd1, 32'h0, "R8");

    // same-cycle read and write (R9)
    rd(3'd5, 0, "R9");
    rd(3'd5, 0, "R9");
    step(1, 3'd4, 3'd2, 1, 3'd5, 32'h0, "R9");
    step(1, 3'd0, 3'd0, 1, 3'd4, 32'h0, "R9");
    step(1, 3'd1, 3'd0, 1, 3'd1, 32'h3, "R9");
    rd(3'd4, 3'd7, "R9");
    rd(3'd4, 3'd7, "R9");
    step(1, 3'd4, 3'd1, 1, 3'd4, 32'h0, "R9");

    // saturation (R4)
    for (int i = 0; i < MAXC + 2; i++) wr(3'd5, 32'(i), "R4");
    rd(3'd0, 0, "R4");
    rd(3'd5, 0, "R1");

    // mixed traffic (R1 R2 R3 R5 R9)
    for (int i = 0; i < 4000; i++) begin
      step(bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
           bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), $urandom,
           "R1 R2 R3 R5 R9 mix");
      if (i == 1000) begin
        while (m_cnt > 0) rd(3'd5, 0, "R1 drain");
      end
    end
    idle("R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule